// File: doc/BRIEF.md
# Microcoded Accumulator Operate Unit

This unit carries out the register-only "operate" instructions that act on a 12-bit accumulator and its 1-bit link (carry) register. One instruction word can set several independent micro-action bits. The unit decodes them and applies them in a fixed priority order to the 13-bit value formed by link and accumulator, so a single word can clear, complement, increment, rotate or half-swap the state.

The order lets one word build small constants, form a two's-complement negation, or rotate a carry into the accumulator. The new link and accumulator appear combinationally from the current inputs. When `valid_i` is high they are also captured in an output register, and a one-cycle done pulse follows.

Words outside this instruction group pass the state through unchanged. Memory-reference instructions, skip logic and instruction fetch live elsewhere.

Top module: `acc_opr_unit`

## Requirements
- R1: A word belongs to the group only when instr[11:9] = 3'b111 and instr[8] = 0. Any other word leaves `acc_c_o`/`link_c_o` equal to `acc_i`/`link_i`.
- R2: Step 1 (clears). instr[7] (octal 0200) clears the accumulator and instr[6] (octal 0100) clears the link, before any other step.
- R3: Step 2 (complements). instr[5] (octal 0040) inverts the accumulator and instr[4] (octal 0020) inverts the link, after the clears. For example, 7240 gives an accumulator of 7777.
- R4: Step 3 (increment). instr[0] (octal 0001) adds one to the 13-bit {link, accumulator}, so a carry out of the accumulator toggles the link. 7041 (complement, then increment) gives the two's-complement negation.
- R5: Step 4 (rotate). instr[3] (octal 0010) rotates {link, accumulator} right by one and instr[2] (octal 0004) rotates it left by one. The bit leaving one end enters the other end through the link.
- R6: instr[1] (octal 0002) with exactly one rotate bit set makes that rotate move two positions.
- R7: instr[1] with neither rotate bit set swaps accumulator bits [11:6] with bits [5:0] and leaves the link unchanged.
- R8: With both rotate bits set, step 4 does nothing, whatever the value of instr[1].
- R9: A group word with no action bits (7000) leaves link and accumulator unchanged. The constants 7301 → 0001 and 7305 → 0002 arise from the ordering, with the link at 0 in both cases.
- R10: Reset clears `acc_q_o`, `link_q_o` and `done_o`. When `valid_i` is high at a clock edge, the registers load the combinational result and `done_o` is 1 for the following cycle. When `valid_i` is low, the registers hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Capture strobe for the result register |
| instr_i | input | 12 | Instruction word |
| acc_i | input | 12 | Current accumulator |
| link_i | input | 1 | Current link |
| acc_c_o | output | 12 | Combinational new accumulator |
| link_c_o | output | 1 | Combinational new link |
| acc_q_o | output | 12 | Registered accumulator |
| link_q_o | output | 1 | Registered link |
| done_o | output | 1 | High for the cycle after a capture |

## Verification
The carry from the increment step and the rotate step can fall on the same instruction. The carry toggles the link, and the rotate then pulls that new link into the accumulator. The bench provokes this with an all-ones accumulator under 7005 and 7011 (increment plus rotate), and with a sweep of every group word over varied accumulator values. Each result is judged against a reference model that applies the four steps in order on a plain 13-bit integer. The combinational outputs are compared before the clock edge and the registered outputs after it.

// File: rtl/aou_pkg.sv
package aou_pkg;
  localparam int unsigned IW = 12;

  typedef enum logic [2:0] {
    S4_NONE = 3'd0,
    S4_ROR1 = 3'd1,
    S4_ROR2 = 3'd2,
    S4_ROL1 = 3'd3,
    S4_ROL2 = 3'd4,
    S4_SWAP = 3'd5
  } s4_mode_t;

  typedef struct packed {
    logic grp1;
    logic clr_acc;
    logic clr_lnk;
    logic cmp_acc;
    logic cmp_lnk;
    logic rot_r;
    logic rot_l;
    logic twice;
    logic inc;
  } aou_ctl_t;
endpackage

// File: rtl/aou_decode.sv
module aou_decode
  import aou_pkg::*;
(
  input  logic [IW-1:0] instr_i,
  output aou_ctl_t      ctl_o,
  output s4_mode_t      mode_o
);
  logic grp1;

  // group membership: top three bits all ones, bit 8 low
  assign grp1 = (instr_i[11:9] == 3'b111) && !instr_i[8];

  always_comb begin
    ctl_o.grp1    = grp1;
    ctl_o.clr_acc = grp1 & instr_i[7];
    ctl_o.clr_lnk = grp1 & instr_i[6];
    ctl_o.cmp_acc = grp1 & instr_i[5];
    ctl_o.cmp_lnk = grp1 & instr_i[4];
    ctl_o.rot_r   = grp1 & instr_i[3];
    ctl_o.rot_l   = grp1 & instr_i[2];
    ctl_o.twice   = grp1 & instr_i[1];
    ctl_o.inc     = grp1 & instr_i[0];
  end

  always_comb begin
    unique case ({ctl_o.rot_r, ctl_o.rot_l, ctl_o.twice})
      3'b100:  mode_o = S4_ROR1;
      3'b101:  mode_o = S4_ROR2;
      3'b010:  mode_o = S4_ROL1;
      3'b011:  mode_o = S4_ROL2;
      3'b001:  mode_o = S4_SWAP;
      default: mode_o = S4_NONE;
    endcase
  end
endmodule

// File: rtl/aou_logic_stage.sv
module aou_logic_stage #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_acc_i,
  input  logic          clr_lnk_i,
  input  logic          cmp_acc_i,
  input  logic          cmp_lnk_i,
  input  logic [DW-1:0] acc_i,
  input  logic          lnk_i,
  output logic [DW-1:0] acc_o,
  output logic          lnk_o
);
  logic [DW-1:0] acc_s1;
  logic          lnk_s1;

  function automatic logic [DW-1:0] clear_or_keep(input logic [DW-1:0] v, input logic clr);
    return clr ? '0 : v;
  endfunction

  function automatic logic [DW-1:0] flip_if(input logic [DW-1:0] v, input logic f);
    return f ? ~v : v;
  endfunction

  // step 1: clears
  assign acc_s1 = clear_or_keep(acc_i, clr_acc_i);
  assign lnk_s1 = clr_lnk_i ? 1'b0 : lnk_i;

  // step 2: complements
  assign acc_o = flip_if(acc_s1, cmp_acc_i);
  assign lnk_o = lnk_s1 ^ cmp_lnk_i;

  p_clear_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_acc_i && !cmp_acc_i) |-> (acc_o == '0));
  p_clear_lnk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lnk_i && !cmp_lnk_i) |-> (lnk_o == 1'b0));
  p_cla_cma_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_acc_i && cmp_acc_i) |-> (&acc_o));
  p_cml_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_lnk_i && cmp_lnk_i) |-> (lnk_o != lnk_i));
endmodule

// File: rtl/aou_inc_stage.sv
module aou_inc_stage #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic [DW-1:0] acc_i,
  input  logic          lnk_i,
  output logic [DW-1:0] acc_o,
  output logic          lnk_o,
  output logic          carry_o
);
  localparam int unsigned VW = DW + 1;

  logic [VW-1:0] sum;

  function automatic logic [VW-1:0] bump(input logic [VW-1:0] v, input logic en);
    return v + {{(VW-1){1'b0}}, en};
  endfunction

  assign sum     = bump({lnk_i, acc_i}, inc_i);
  assign acc_o   = sum[DW-1:0];
  assign lnk_o   = sum[DW];
  assign carry_o = lnk_o ^ lnk_i;

  p_wrap_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && (&acc_i)) |-> ((acc_o == '0) && (lnk_o != lnk_i)));
  p_no_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !(&acc_i)) |-> ((lnk_o == lnk_i) && (acc_o != acc_i)));
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |-> ((acc_o == acc_i) && (lnk_o == lnk_i)));
endmodule

// File: rtl/aou_rot_stage.sv
module aou_rot_stage
  import aou_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  s4_mode_t      mode_i,
  input  logic          rot_r_i,
  input  logic          rot_l_i,
  input  logic          twice_i,
  input  logic [DW-1:0] acc_i,
  input  logic          lnk_i,
  output logic [DW-1:0] acc_o,
  output logic          lnk_o
);
  localparam int unsigned VW   = DW + 1;
  localparam int unsigned HALF = DW / 2;

  logic [VW-1:0] v_in, ror1, ror2, rol1, rol2, swp, v_out;

  assign v_in = {lnk_i, acc_i};

  // each candidate bit is wired from its source position
  for (genvar i = 0; i < VW; i++) begin : g_rot
    assign ror1[i] = v_in[(i + 1) % VW];
    assign ror2[i] = v_in[(i + 2) % VW];
    assign rol1[i] = v_in[(i + VW - 1) % VW];
    assign rol2[i] = v_in[(i + VW - 2) % VW];
  end

  for (genvar j = 0; j < DW; j++) begin : g_swap
    assign swp[j] = v_in[(j + HALF) % DW];
  end
  assign swp[DW] = v_in[DW];

  always_comb begin
    unique case (mode_i)
      S4_ROR1: v_out = ror1;
      S4_ROR2: v_out = ror2;
      S4_ROL1: v_out = rol1;
      S4_ROL2: v_out = rol2;
      S4_SWAP: v_out = swp;
      default: v_out = v_in;
    endcase
  end

  assign acc_o = v_out[DW-1:0];
  assign lnk_o = v_out[DW];

  p_bits_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(v_out) == $countones(v_in));
  p_ror_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_r_i && !rot_l_i && !twice_i) |-> (lnk_o == acc_i[0]));
  p_rol2_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_l_i && !rot_r_i && twice_i) |-> (lnk_o == acc_i[DW-2]));
  p_swap_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_r_i && !rot_l_i && twice_i) |-> (lnk_o == lnk_i));
  p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_r_i && rot_l_i) |-> ((acc_o == acc_i) && (lnk_o == lnk_i)));
endmodule

// File: rtl/acc_opr_unit.sv
module acc_opr_unit
  import aou_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [IW-1:0] instr_i,
  input  logic [DW-1:0] acc_i,
  input  logic          link_i,
  output logic [DW-1:0] acc_c_o,
  output logic          link_c_o,
  output logic [DW-1:0] acc_q_o,
  output logic          link_q_o,
  output logic          done_o
);
  aou_ctl_t      ctl;
  s4_mode_t      mode;
  logic [DW-1:0] acc_s2, acc_s3;
  logic          lnk_s2, lnk_s3;
  logic          inc_carry;
  logic [DW-1:0] acc_q;
  logic          lnk_q, done_q;

  aou_decode u_dec (
    .instr_i (instr_i),
    .ctl_o   (ctl),
    .mode_o  (mode)
  );

  aou_logic_stage #(.DW(DW)) u_s12 (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_acc_i (ctl.clr_acc),
    .clr_lnk_i (ctl.clr_lnk),
    .cmp_acc_i (ctl.cmp_acc),
    .cmp_lnk_i (ctl.cmp_lnk),
    .acc_i     (acc_i),
    .lnk_i     (link_i),
    .acc_o     (acc_s2),
    .lnk_o     (lnk_s2)
  );

  aou_inc_stage #(.DW(DW)) u_s3 (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (ctl.inc),
    .acc_i   (acc_s2),
    .lnk_i   (lnk_s2),
    .acc_o   (acc_s3),
    .lnk_o   (lnk_s3),
    .carry_o (inc_carry)
  );

  aou_rot_stage #(.DW(DW)) u_s4 (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode),
    .rot_r_i (ctl.rot_r),
    .rot_l_i (ctl.rot_l),
    .twice_i (ctl.twice),
    .acc_i   (acc_s3),
    .lnk_i   (lnk_s3),
    .acc_o   (acc_c_o),
    .lnk_o   (link_c_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lnk_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= valid_i;
      if (valid_i) begin
        acc_q <= acc_c_o;
        lnk_q <= link_c_o;
      end
    end
  end

  assign acc_q_o  = acc_q;
  assign link_q_o = lnk_q;
  assign done_o   = done_q;

  p_outside_group_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.grp1 |-> ((acc_c_o == acc_i) && (link_c_o == link_i)));
  p_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i == 12'o7000) |-> ((acc_c_o == acc_i) && (link_c_o == link_i)));
  p_carry_into_rotl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_carry && mode == S4_ROL1) |-> (acc_c_o[0] == lnk_s3));
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> ((acc_q_o == $past(acc_c_o)) && (link_q_o == $past(link_c_o)) && done_o));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(acc_q_o) && $stable(link_q_o) && !done_o));
endmodule

// File: tb/acc_opr_unit_tb.sv
`timescale 1ns/1ps
module acc_opr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] instr_i = '0;
  logic [11:0] acc_i = '0;
  logic        link_i = 1'b0;
  logic [11:0] acc_c_o, acc_q_o;
  logic        link_c_o, link_q_o, done_o;

  int checks = 0;
  int fails  = 0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  acc_opr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .acc_i(acc_i), .link_i(link_i), .acc_c_o(acc_c_o), .link_c_o(link_c_o),
    .acc_q_o(acc_q_o), .link_q_o(link_q_o), .done_o(done_o)
  );

  // reference: four ordered steps on a plain 13-bit integer
  function automatic logic [12:0] ref_model(input logic [11:0] ins, input logic [11:0] a,
                                            input logic l);
    int ac, lk, v, n;
    if (ins[11:9] != 3'b111 || ins[8]) return {l, a};
    ac = int'(a);
    lk = int'(l);
    if (ins[7]) ac = 0;
    if (ins[6]) lk = 0;
    if (ins[5]) ac = ac ^ 'hFFF;
    if (ins[4]) lk = lk ^ 1;
    v = lk * 4096 + ac;
    if (ins[0]) v = (v + 1) % 8192;
    n = ins[1] ? 2 : 1;
    if (ins[3] && !ins[2]) begin
      repeat (n) v = (v / 2) + ((v % 2) * 4096);
    end else if (ins[2] && !ins[3]) begin
      repeat (n) v = ((v * 2) % 8192) + (v / 4096);
    end else if (!ins[2] && !ins[3] && ins[1]) begin
      v = (v & 'h1000) | ((v % 64) * 64) | ((v / 64) % 64);
    end
    return v[12:0];
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%o expected=%o", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // driver: applies one word, checks the combinational result, queues the registered one
  task automatic apply(input logic [11:0] ins, input logic [11:0] a, input logic l,
                       input string req);
    logic [12:0] e;
    @(negedge clk);
    instr_i = ins; acc_i = a; link_i = l; valid_i = 1'b1;
    e = ref_model(ins, a, l);
    #1;
    check({req, " comb"}, {link_c_o, acc_c_o}, e);
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  // monitor: pops one expected item per done pulse
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && done_o) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected done", 13'd1, 13'd0);
        end else begin
          logic [12:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " reg"}, {link_q_o, acc_q_o}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [11:0] lfsr;
    lfsr = 12'hACE;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset", {done_o, link_q_o, acc_q_o}, 13'd0);
    @(negedge clk);
    rst_n = 1'b1;

    apply(12'o7000, 12'o1234, 1'b1, "R9 nop");
    apply(12'o7301, 12'o5555, 1'b1, "R9 const one");
    apply(12'o7305, 12'o5555, 1'b1, "R9 const two");
    apply(12'o7200, 12'o4321, 1'b1, "R2 clear acc");
    apply(12'o7100, 12'o4321, 1'b1, "R2 clear link");
    apply(12'o7240, 12'o0123, 1'b0, "R3 cla cma");
    apply(12'o7020, 12'o0123, 1'b0, "R3 cml");
    apply(12'o7041, 12'o0005, 1'b0, "R4 negate");
    apply(12'o7041, 12'o0000, 1'b0, "R4 negate zero carry");
    apply(12'o7001, 12'o7777, 1'b1, "R4 wrap toggles link");
    apply(12'o7005, 12'o7777, 1'b0, "R4 carry then ral");
    apply(12'o7011, 12'o7777, 1'b0, "R4 carry then rar");
    apply(12'o7010, 12'o0001, 1'b0, "R5 rar");
    apply(12'o7004, 12'o4000, 1'b0, "R5 ral");
    apply(12'o7012, 12'o0003, 1'b0, "R6 rtr");
    apply(12'o7006, 12'o6000, 1'b1, "R6 rtl");
    apply(12'o7002, 12'o1234, 1'b1, "R7 swap");
    apply(12'o7014, 12'o1234, 1'b1, "R8 both rot");
    apply(12'o7016, 12'o4321, 1'b0, "R8 both rot twice");
    apply(12'o7401, 12'o1234, 1'b0, "R1 bit8 set");
    apply(12'o5377, 12'o1234, 1'b1, "R1 other opcode");

    // hold: inputs change without a strobe, registers keep the last result
    @(negedge clk);
    valid_i = 1'b0;
    instr_i = 12'o7240; acc_i = 12'o0707; link_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 hold", {link_q_o, acc_q_o}, ref_model(12'o5377, 12'o1234, 1'b1));
    check("R10 done low", {12'd0, done_o}, 13'd0);

    // sweep every group word
    for (int i = 0; i < 256; i++) begin
      lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
      apply(12'o7000 | 12'(i), lfsr, lfsr[5], "R5 sweep");
    end
    @(negedge clk);
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 queue drained", 13'(exp_q.size()), 13'd0);
    finish_run();
  end
endmodule